// File: doc/BRIEF.md
# Masked Alarm Comparator with Interrupt

This block watches a running calendar and raises an alarm when the time reaches a programmed value. It compares four alarm fields with the current calendar: seconds, minutes, hours and day of month. Each field has its own skip bit. When a field's skip bit is clear, that field must match. When the skip bit is set, the field is left out of the comparison. The programmed selection of fields sets how often the alarm can fire. With every field compared, it fires at most once a month. With only seconds compared, it fires once a minute. When all four fields are skipped, the alarm is switched off.

The comparison takes place only on a seconds strobe, which the calendar pulses once each time it advances. A match on that strobe sets a sticky alarm flag. The interrupt output shows the flag gated by an interrupt enable. Software clears the flag by reading the flags register, and that read clears the flag state held here in full. The calendar counters and the register decoding sit outside this block. They supply the field values, the skip bits, the enable and a one-cycle read strobe.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, `alarm_flag` and `irq` are both 0.
- R2: When `sec_tick` is 1 and every field whose skip bit is 0 has a current value equal to its alarm value, `alarm_flag` is 1 from the next clock edge on.
- R3: A field whose skip bit is 1 cannot stop a match, whatever its current and alarm values are.
- R4: With `skip_mask` = 4'b1111, the alarm never fires: `alarm_flag` stays 0 on every `sec_tick`.
- R5: Fields are compared only in a cycle where `sec_tick` is 1. Matching values without a strobe leave `alarm_flag` unchanged.
- R6: `irq` is 1 exactly when `alarm_flag` is 1 and `irq_en` is 1. With `irq_en` = 0, a match still sets `alarm_flag` but `irq` stays 0.
- R7: A cycle with `flags_rd` = 1 and no match event clears `alarm_flag` at the next edge, and `irq` drops with it.
- R8: When a match event and `flags_rd` fall in the same cycle, the new match wins and `alarm_flag` is 1 afterwards.
- R9: `skip_mask` bit 0 belongs to seconds, bit 1 to minutes, bit 2 to hours and bit 3 to the day of month. Each field is compared as its full 8-bit packed BCD byte.
- R10: Once set, `alarm_flag` stays 1 through later strobes that do not match, until a flags read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle strobe that marks a new second of the calendar |
| cur_sec | input | 8 | Current seconds, packed BCD |
| cur_min | input | 8 | Current minutes, packed BCD |
| cur_hour | input | 8 | Current hours, packed BCD |
| cur_date | input | 8 | Current day of month, packed BCD |
| alm_sec | input | 8 | Alarm seconds, packed BCD |
| alm_min | input | 8 | Alarm minutes, packed BCD |
| alm_hour | input | 8 | Alarm hours, packed BCD |
| alm_date | input | 8 | Alarm day of month, packed BCD |
| skip_mask | input | 4 | Per-field skip bits, 1 = leave the field out of the comparison |
| irq_en | input | 1 | Alarm interrupt enable |
| flags_rd | input | 1 | One-cycle strobe for a flags-register read; clears the flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Interrupt output, active high |

## Verification
The assertions assume that `sec_tick` and `flags_rd` are single-cycle strobes produced in the clock domain of `clk`, and that the field values and skip bits do not change in the cycle in which a strobe is sampled. The bench drives every input on the falling clock edge and holds it across the next rising edge. It lowers each strobe straight after the edge that samples it, and changes the alarm registers only while no strobe is active. Field values are legal packed BCD bytes, but the comparison does not depend on that.

// File: rtl/alm_pkg.sv
package alm_pkg;
  parameter int ALM_FW = 8;
  parameter int ALM_NF = 4;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;

  function automatic logic field_hit_f(input logic [ALM_FW-1:0] cur,
                                       input logic [ALM_FW-1:0] alm,
                                       input logic skip);
    return skip | (cur == alm);
  endfunction

  function automatic logic flag_next_f(input logic flag,
                                       input logic set_ev,
                                       input logic rd);
    return set_ev | (flag & ~rd);
  endfunction
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp import alm_pkg::*; #(
  parameter int FW = ALM_FW
) (
  input  logic [FW-1:0] cur,
  input  logic [FW-1:0] alm,
  input  logic          skip,
  output logic          hit
);
  always_comb hit = field_hit_f(cur, alm, skip);
endmodule

// File: rtl/alm_match_combine.sv
module alm_match_combine #(
  parameter int NF = 4
) (
  input  logic [NF-1:0] field_hit,
  input  logic [NF-1:0] skip_mask,
  output logic          all_skipped,
  output logic          alarm_hit
);
  always_comb begin
    all_skipped = &skip_mask;
    alarm_hit   = ~all_skipped & (&field_hit);
  end
endmodule

// File: rtl/alm_flag_reg.sv
module alm_flag_reg import alm_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next_f(flag, set_ev, rd);
  end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit import alm_pkg::*; #(
  parameter int FW = ALM_FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [FW-1:0] cur_sec,
  input  logic [FW-1:0] cur_min,
  input  logic [FW-1:0] cur_hour,
  input  logic [FW-1:0] cur_date,
  input  logic [FW-1:0] alm_sec,
  input  logic [FW-1:0] alm_min,
  input  logic [FW-1:0] alm_hour,
  input  logic [FW-1:0] alm_date,
  input  logic [3:0]    skip_mask,
  input  logic          irq_en,
  input  logic          flags_rd,
  output logic          alarm_flag,
  output logic          irq
);
  localparam int NF = ALM_NF;

  logic [NF*FW-1:0] cur_flat;
  logic [NF*FW-1:0] alm_flat;
  logic [NF-1:0]    field_hit;
  logic             all_skipped;
  logic             alarm_hit;
  logic             flag_set;

  assign cur_flat = {cur_date, cur_hour, cur_min, cur_sec};
  assign alm_flat = {alm_date, alm_hour, alm_min, alm_sec};

  for (genvar g = 0; g < NF; g++) begin : g_field
    alm_field_cmp #(.FW(FW)) u_cmp (
      .cur  (cur_flat[g*FW +: FW]),
      .alm  (alm_flat[g*FW +: FW]),
      .skip (skip_mask[g]),
      .hit  (field_hit[g])
    );
  end

  alm_match_combine #(.NF(NF)) u_comb (
    .field_hit   (field_hit),
    .skip_mask   (skip_mask),
    .all_skipped (all_skipped),
    .alarm_hit   (alarm_hit)
  );

  assign flag_set = sec_tick & alarm_hit;

  alm_flag_reg u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (flag_set),
    .rd     (flags_rd),
    .flag   (alarm_flag)
  );

  assign irq = alarm_flag & irq_en;
endmodule

// File: rtl/alm_match_checker.sv
module alm_match_checker #(
  parameter int FW = 8,
  parameter int NF = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_tick,
  input logic [NF*FW-1:0] cur_flat,
  input logic [NF*FW-1:0] alm_flat,
  input logic [NF-1:0] skip_mask,
  input logic          irq_en,
  input logic          flags_rd,
  input logic          alarm_hit,
  input logic          all_skipped,
  input logic          alarm_flag,
  input logic          irq
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> !alarm_flag);

  a_r2_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && alarm_hit) |=> alarm_flag);

  for (genvar g = 0; g < NF; g++) begin : g_fchk
    a_r3_field_ok: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |-> (skip_mask[g] || cur_flat[g*FW +: FW] == alm_flat[g*FW +: FW]));
  end

  a_r4_all_skip_off: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_mask == '1) |-> (all_skipped && !alarm_hit));

  a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !flags_rd) |=> $stable(alarm_flag));

  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> alarm_flag);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && !(sec_tick && alarm_hit)) |=> !alarm_flag);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && sec_tick && alarm_hit) |=> alarm_flag);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !flags_rd) |=> alarm_flag);
endmodule

bind alarm_match_unit alm_match_checker #(.FW(FW), .NF(NF)) u_alm_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_tick    (sec_tick),
  .cur_flat    (cur_flat),
  .alm_flat    (alm_flat),
  .skip_mask   (skip_mask),
  .irq_en      (irq_en),
  .flags_rd    (flags_rd),
  .alarm_hit   (alarm_hit),
  .all_skipped (all_skipped),
  .alarm_flag  (alarm_flag),
  .irq         (irq)
);

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00, cur_date = 8'h01;
  logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00, alm_date = 8'h01;
  logic [3:0] skip_mask = 4'b0000;
  logic       irq_en = 1'b0;
  logic       flags_rd = 1'b0;
  logic       alarm_flag, irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  alarm_match_unit i_alarm_match_unit (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .alm_date(alm_date),
    .skip_mask(skip_mask), .irq_en(irq_en), .flags_rd(flags_rd),
    .alarm_flag(alarm_flag), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one clock with the given strobes; outputs sampled 1 ns after the edge
  task automatic step(input logic tick, input logic rd);
    @(negedge clk);
    sec_tick = tick;
    flags_rd = rd;
    @(posedge clk);
    #1;
    sec_tick = 1'b0;
    flags_rd = 1'b0;
  endtask

  task automatic set_now(input logic [7:0] d, h, m, s);
    @(negedge clk);
    cur_date = d; cur_hour = h; cur_min = m; cur_sec = s;
  endtask

  task automatic set_alarm(input logic [7:0] d, h, m, s, input logic [3:0] msk);
    @(negedge clk);
    alm_date = d; alm_hour = h; alm_min = m; alm_sec = s; skip_mask = msk;
  endtask

  task automatic clear_flag();
    step(1'b0, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 flag after reset", alarm_flag, 1'b0);
    check("R1 irq after reset", irq, 1'b0);
  endtask

  task automatic t_exact();
    irq_en = 1'b1;
    set_alarm(8'h15, 8'h23, 8'h59, 8'h30, 4'b0000);
    set_now(8'h15, 8'h23, 8'h59, 8'h30);
    step(1'b1, 1'b0);
    check("R2 exact match flag", alarm_flag, 1'b1);
    check("R6 irq with enable", irq, 1'b1);
    clear_flag();
    check("R7 read clears flag", alarm_flag, 1'b0);
    check("R7 irq drops", irq, 1'b0);
  endtask

  task automatic t_mismatch();
    set_now(8'h15, 8'h23, 8'h59, 8'h31);
    step(1'b1, 1'b0);
    check("R2 seconds mismatch", alarm_flag, 1'b0);
    set_now(8'h16, 8'h23, 8'h59, 8'h30);
    step(1'b1, 1'b0);
    check("R2 date mismatch", alarm_flag, 1'b0);
  endtask

  task automatic t_masked();
    // R9: bit3 = date skipped, date differs
    set_alarm(8'h01, 8'h08, 8'h45, 8'h10, 4'b1000);
    set_now(8'h27, 8'h08, 8'h45, 8'h10);
    step(1'b1, 1'b0);
    check("R3 skipped date ignored", alarm_flag, 1'b1);
    clear_flag();
    // R9: only date compared (bits 2..0 skip), seconds differ
    set_alarm(8'h27, 8'h00, 8'h00, 8'h00, 4'b0111);
    set_now(8'h27, 8'h11, 8'h22, 8'h33);
    step(1'b1, 1'b0);
    check("R9 date-only bit order", alarm_flag, 1'b1);
    clear_flag();
    // R9: skip seconds only (bit0); minutes differ in one BCD digit -> no match
    set_alarm(8'h27, 8'h11, 8'h12, 8'h00, 4'b0001);
    step(1'b1, 1'b0);
    check("R9 minutes full byte compared", alarm_flag, 1'b0);
  endtask

  task automatic t_all_skip();
    set_alarm(8'h27, 8'h11, 8'h22, 8'h33, 4'b1111);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    check("R4 all skipped never fires", alarm_flag, 1'b0);
  endtask

  task automatic t_no_tick();
    set_alarm(8'h27, 8'h11, 8'h22, 8'h33, 4'b0000);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    check("R5 no strobe no flag", alarm_flag, 1'b0);
  endtask

  task automatic t_irq_off();
    irq_en = 1'b0;
    step(1'b1, 1'b0);
    check("R6 flag set with irq off", alarm_flag, 1'b1);
    check("R6 irq masked", irq, 1'b0);
    @(negedge clk); irq_en = 1'b1; #1;
    check("R6 irq follows enable", irq, 1'b1);
  endtask

  task automatic t_sticky();
    set_now(8'h27, 8'h11, 8'h22, 8'h34);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check("R10 flag sticky", alarm_flag, 1'b1);
    clear_flag();
    check("R7 sticky flag cleared", alarm_flag, 1'b0);
  endtask

  task automatic t_collide();
    set_now(8'h27, 8'h11, 8'h22, 8'h33);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R8 match beats read", alarm_flag, 1'b1);
    clear_flag();
    check("R7 clear after collision", alarm_flag, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_exact();
    t_mismatch();
    t_masked();
    t_all_skip();
    t_no_tick();
    t_irq_off();
    t_sticky();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule